// File: doc/BRIEF.md
# Mode-0 SPI Byte Controller with Programmable Data-Out Idle Level

The block moves one byte out and one byte in per transfer over a four-wire serial link. It uses clock mode 0: the serial clock rests low, and both sides take in data on the rising edge. A one-cycle start request carries the byte to send. The serial clock rate comes from a divider input. When the exchange is over, the block returns the received byte together with a one-cycle completion strobe.

The data-out line follows a programmable rest policy. A configuration word sets it. Under the keep policy the line keeps the last bit it sent. The other two policies pin it low or high at every moment no bit is being driven: while chip select is inactive, and also inside chip select after the last bit. Some peripherals need the line parked at a known level, and these two policies serve them. If a write sets both force bits at once, the block holds an error flag high and will not start a transfer.

Top module: `spi_idle_ctrl`

## Requirements
- R1: With chip select inactive, the serial clock is low. While the serial clock is high, the data-out line does not change.
- R2: The transmit byte leaves the block most significant bit first, one bit for each rising serial clock edge, eight rising edges per transfer.
- R3: The data-in line is sampled on each rising serial clock edge, most significant bit first. The assembled byte appears on rx_byte in the same cycle as done.
- R4: One serial clock period is 2*(clk_div+1) system clock cycles.
- R5: Chip select goes low clk_div+1 system clocks before the first rising edge. It goes high clk_div+1 system clocks after the eighth falling edge.
- R6: When configuration bit 18 alone is set, the data-out line is high from the eighth falling edge onward, and it stays high for as long as chip select is inactive.
- R7: When configuration bit 17 alone is set, the data-out line is low at those same times.
- R8: When neither bit 17 nor bit 18 is set, the data-out line keeps the last bit sent (bit 0 of the byte) after the transfer. All other configuration bits have no effect.
- R9: When bits 17 and 18 are both set, cfg_err is 1 and a start request produces no chip select activity and no done. Writing a valid policy clears cfg_err and restores normal operation.
- R10: done is high for exactly one system clock per transfer. A start request that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| tx_byte | input | 8 | Byte to send, taken with start |
| clk_div | input | 8 | Half-period length minus one, in system clocks |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration word (bit 17 force low, bit 18 force high) |
| miso | input | 1 | Serial data in |
| rx_byte | output | 8 | Received byte, valid with done |
| done | output | 1 | One-cycle transfer completion |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Both force bits requested |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |

## Verification
Each rest policy is run with bytes whose last bit differs, such as 0xA5, 0x5A, 0x81, 0x00 and 0xFF. A wrong rest level therefore cannot match by chance, and a keep-last line can be told apart from a forced one. The modelled peripheral answers with bytes whose pattern differs from the transmit byte, which exposes crossed shift directions and swapped lanes. Divider values 0 through 3 separate the edge spacing from a fixed half period. A second start sent in the middle of a transfer, a configuration with both bits set, and a configuration with extra unrelated bits set test rejection and the ignored bits.

// File: rtl/spi_idle_pkg.sv
package spi_idle_pkg;
  localparam int CFG_W       = 32;
  localparam int IDLE_LO_BIT = 17;
  localparam int IDLE_HI_BIT = 18;

  typedef enum logic [1:0] {
    POL_KEEP  = 2'd0,
    POL_LOW   = 2'd1,
    POL_HIGH  = 2'd2
  } idle_pol_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LO    = 2'd1,
    ST_HI    = 2'd2,
    ST_TRAIL = 2'd3
  } eng_st_t;
endpackage

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg
  import spi_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic      want_low,
  input  logic      want_high,
  output idle_pol_t policy,
  output logic      conflict
);
  always_ff @(posedge clk) begin
    if (rst) begin
      policy   <= POL_KEEP;
      conflict <= 1'b0;
    end else if (we) begin
      conflict <= want_low & want_high;
      if (want_low && !want_high)      policy <= POL_LOW;
      else if (want_high && !want_low) policy <= POL_HIGH;
      else                             policy <= POL_KEEP;
    end
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_idle_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  idle_pol_t         policy,
  input  logic              conflict,
  input  logic              miso,
  input  logic              tick,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              done
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  eng_st_t           st;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [IDX_W-1:0]  bit_idx;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (policy == POL_LOW)       mosi <= 1'b0;
          else if (policy == POL_HIGH) mosi <= 1'b1;
          if (start && !conflict) begin
            tx_sh   <= tx_data;
            mosi    <= tx_data[DATA_W-1];
            cs_n    <= 1'b0;
            bit_idx <= TOP_IDX;
            st      <= ST_LO;
          end
        end
        ST_LO: if (tick) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[DATA_W-2:0], miso};
          st    <= ST_HI;
        end
        ST_HI: if (tick) begin
          sclk <= 1'b0;
          if (bit_idx == '0) begin
            st <= ST_TRAIL;
            if (policy == POL_LOW)       mosi <= 1'b0;
            else if (policy == POL_HIGH) mosi <= 1'b1;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            mosi    <= tx_sh[bit_idx - 1'b1];
            st      <= ST_LO;
          end
        end
        ST_TRAIL: if (tick) begin
          cs_n    <= 1'b1;
          done    <= 1'b1;
          rx_data <= rx_sh;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_sclk_rest_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_mosi_steady_r1: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_refuse_conflict_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && conflict) |=> cs_n);
endmodule

// File: rtl/spi_idle_ctrl.sv
module spi_idle_ctrl
  import spi_idle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              miso,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              busy,
  output logic              cfg_err,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi
);
  idle_pol_t policy;
  logic      tick;
  logic      unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:IDLE_HI_BIT+1], cfg_wdata[IDLE_LO_BIT-1:0]};

  spi_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .want_low  (cfg_wdata[IDLE_LO_BIT]),
    .want_high (cfg_wdata[IDLE_HI_BIT]),
    .policy    (policy),
    .conflict  (cfg_err)
  );

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (clk_div),
    .tick (tick)
  );

  spi_shift_eng #(.DATA_W(DATA_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tx_data  (tx_byte),
    .policy   (policy),
    .conflict (cfg_err),
    .miso     (miso),
    .tick     (tick),
    .busy     (busy),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .rx_data  (rx_byte),
    .done     (done)
  );

  p_rest_high_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && policy == POL_HIGH && $past(policy) == POL_HIGH) |-> mosi);

  p_rest_low_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && policy == POL_LOW && $past(policy) == POL_LOW) |-> !mosi);

  p_err_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> policy == POL_KEEP);
endmodule

// File: tb/sim_spi_idle_ctrl.sv
`timescale 1ns/1ps
module sim_spi_idle_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic [7:0]  clk_div = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        miso = 1'b0;
  logic [7:0]  rx_byte;
  logic        done, busy, cfg_err, sclk, cs_n, mosi;

  always #5 clk = ~clk;

  spi_idle_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte), .clk_div(clk_div),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .miso(miso), .rx_byte(rx_byte),
    .done(done), .busy(busy), .cfg_err(cfg_err), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  typedef struct packed { logic [7:0] tx; logic [7:0] resp; logic [7:0] div; } item_t;
  item_t exp_q[$];

  int total = 0, bad = 0;
  int done_cnt = 0, cs_falls = 0;
  int pol_b = 0;          // 0 keep, 1 low, 2 high
  logic [7:0] resp_cur = '0, last_tx = '0, pcap = '0;
  int nbits = 0;
  bit chk_tail = 0;
  time t_cs_fall, t_r1, t_r2, t_fall, t_cs_rise;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic rest_level();
    if (pol_b == 2) return 1'b1;
    if (pol_b == 1) return 1'b0;
    return last_tx[0];
  endfunction

  // peripheral model
  always @(negedge cs_n) if (cs_n === 1'b0) begin
    cs_falls++; pcap = '0; nbits = 0; t_cs_fall = $time; miso = resp_cur[7];
  end
  always @(posedge cs_n) if (cs_n === 1'b1) t_cs_rise = $time;
  always @(posedge sclk) if (cs_n === 1'b0) begin
    pcap = {pcap[6:0], mosi}; nbits++;
    if (nbits == 1) t_r1 = $time;
    if (nbits == 2) t_r2 = $time;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    t_fall = $time;
    if (nbits == 8) chk_tail = 1;
    else miso = resp_cur[7 - nbits];
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (chk_tail && cs_n === 1'b0) begin
      chk_tail = 0;
      check(mosi == rest_level(), "R6/R7/R8 rest level inside cs after last bit", mosi, rest_level());
    end
    if (done === 1'b1) begin
      item_t it;
      done_cnt++;
      if (exp_q.size() == 0) check(0, "R10 unexpected done", 1, 0);
      else begin
        it = exp_q.pop_front();
        check(rx_byte == it.resp, "R3 received byte", rx_byte, it.resp);
        check(pcap == it.tx, "R2 bits seen by peripheral", pcap, it.tx);
        check((t_r2 - t_r1) == 20 * (it.div + 1), "R4 sclk period ns", int'(t_r2 - t_r1), 20 * (it.div + 1));
        check((t_r1 - t_cs_fall) == 10 * (it.div + 1), "R5 cs lead ns", int'(t_r1 - t_cs_fall), 10 * (it.div + 1));
        check((t_cs_rise - t_fall) == 10 * (it.div + 1), "R5 cs trail ns", int'(t_cs_rise - t_fall), 10 * (it.div + 1));
      end
    end
  end

  task automatic write_cfg(input logic [31:0] w, input int pol);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0; pol_b = pol;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] resp, input logic [7:0] dv);
    item_t it;
    int d0;
    it.tx = tx; it.resp = resp; it.div = dv;
    exp_q.push_back(it);
    d0 = done_cnt;
    @(negedge clk); clk_div = dv; tx_byte = tx; resp_cur = resp; start = 1'b1;
    @(negedge clk); start = 1'b0; last_tx = tx;
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0, "R1 rest state after transfer", {cs_n, sclk}, 2'b10);
    check(mosi == rest_level(), "R6/R7/R8 rest level outside cs", mosi, rest_level());
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !done && !mosi && !busy && !cfg_err, "R1 reset state",
          {cs_n, sclk, done, mosi, busy, cfg_err}, 6'b100000);

    // R8: keep policy, extra bits set elsewhere are ignored
    write_cfg(32'h0000_0109, 0);
    xfer(8'hA5, 8'h3C, 8'd1);
    xfer(8'h5A, 8'hC3, 8'd0);
    // R7: force low, with unrelated bits
    write_cfg(32'h8002_0004, 1);
    check(cfg_err == 1'b0, "R7 no error for single bit", cfg_err, 0);
    xfer(8'h81, 8'h7E, 8'd0);
    xfer(8'hFF, 8'h01, 8'd2);
    // R6: force high
    write_cfg(32'h0004_0000, 2);
    xfer(8'h00, 8'hBA, 8'd3);
    xfer(8'h56, 8'hBA, 8'd1);

    // R10: second start while busy is ignored
    d0 = done_cnt;
    exp_q.push_back('{tx: 8'h96, resp: 8'h69, div: 8'd2});
    @(negedge clk); clk_div = 8'd2; tx_byte = 8'h96; resp_cur = 8'h69; start = 1'b1;
    @(negedge clk); start = 1'b0; last_tx = 8'h96;
    repeat (6) @(negedge clk);
    tx_byte = 8'h11; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    repeat (80) @(negedge clk);
    check(done_cnt == d0 + 1, "R10 start while busy ignored", done_cnt - d0, 1);
    check(cs_n == 1'b1, "R10 no extra transfer", cs_n, 1);

    // R9: conflicting request
    write_cfg(32'h0006_0000, 0);
    check(cfg_err == 1'b1, "R9 error flag", cfg_err, 1);
    c0 = cs_falls; d0 = done_cnt;
    @(negedge clk); tx_byte = 8'h3C; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    check(cs_falls == c0, "R9 cs never asserted", cs_falls - c0, 0);
    check(done_cnt == d0, "R9 no done", done_cnt - d0, 0);
    // recovery
    write_cfg(32'h0004_0000, 2);
    check(cfg_err == 1'b0, "R9 error cleared", cfg_err, 0);
    xfer(8'hC7, 8'h2D, 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule